// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets software talk to an Ethernet PHY over the two-wire management bus. Software writes a single 32-bit command word. That word holds the full image of a clause-22 management frame: the start code, the opcode, the PHY address, the register address, the turnaround pattern and 16 data bits. The controller sends a preamble of 32 ones on MDIO and then shifts the 32 command bits out, most significant bit first. The MDC clock is derived by dividing the bus clock by 48 or by 64.

For a read frame, the controller releases the MDIO line from the second turnaround bit onward. It samples the 16 bits returned by the PHY on rising MDC edges and writes them into the low half of the command word. Software polls an idle bit in the status register to learn when the frame has finished and when the next command may be written. The MDIO pin is split into an output, an output enable and an input.

The sequencer has four states:
- **ST_IDLE**: waiting for a command.
- **ST_PREAMBLE**: sending the 32 ones.
- **ST_FRAME**: sending, or for a read partly receiving, the 32 frame bits.
- **ST_WRAP**: a single cycle that writes back read data.

The transitions are:
- **start**: ST_IDLE to ST_PREAMBLE, on a command write while enabled and idle.
- **pre_done**: ST_PREAMBLE to ST_FRAME, on the falling MDC edge that ends preamble bit 32.
- **frame_done**: ST_FRAME to ST_WRAP, on the falling MDC edge that ends frame bit 0.
- **wrap**: ST_WRAP to ST_IDLE, unconditionally.
- **abort**: ST_PREAMBLE or ST_FRAME to ST_IDLE, when the enable bit is cleared.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the status register reads 0x4, the command register reads 0, and mdc and mdio_oe are 0.
- R2: Registers are selected by word address: 0 is control (bit 4 enables the port), 1 is config (bit 0 selects the divider), 2 is status (bit 2 is idle, read-only) and 3 is the command word. Control and config read back what was written.
- R3: A frame on MDIO, taken at each rising MDC edge, is 32 ones followed by command bits 31 down to 0. In the command word, bit 30 and bit 17 are the fixed start and turnaround ones, bit 29 means read, bit 28 means write, bits 27:23 are the PHY address, bits 22:18 are the register address and bits 15:0 are the data.
- R4: While a frame runs, mdio_o changes only on the clock edge where MDC falls. mdio_o and mdc change together.
- R5: The MDC period is 48 bus clocks when config bit 0 is 0 and 64 bus clocks when it is 1.
- R6: In a write frame (bit 28 set, bit 29 clear), mdio_oe is 1 at every one of the 64 rising MDC edges.
- R7: In a read frame (bit 29 set, bit 28 clear), mdio_oe is 0 from frame bit 16 (the second turnaround bit) to the end of the frame. The 16 bits on mdio_i at the rising edges of frame bits 15 to 0 replace command bits 15:0, MSB first. Command bits 31:16 are unchanged.
- R8: The idle bit reads 0 from the cycle after the command write until the frame ends, and reads 1 afterwards.
- R9: A command write while a frame is in progress is ignored. The frame on the wire and the command register both keep the original command.
- R10: With control bit 4 clear, a command write is ignored and mdc and mdio_oe stay 0. Clearing the bit in the middle of a frame returns the engine to idle at once, with mdc and mdio_oe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Frames are run with both opcodes and both divider settings. This shows that the output-enable pattern follows the opcode and is independent of the clock rate. The write data patterns 0xA5C3 and 0xFFFF, with PHY and register addresses up to 31, show that each bit lands in its own slot and is not smeared across neighbours. The read data patterns 0xBEEF and 0x8001 show that the capture window starts exactly at frame bit 15 and ends at frame bit 0. A command write in the middle of a frame, a write while disabled, and an abort in the middle of a frame followed by a clean frame separate the ignore rule from the abort rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int OP_RD_BIT  = 29;
    localparam int OP_WR_BIT  = 28;
    localparam int EN_BIT     = 4;
    localparam int IDLE_BIT   = 2;
    localparam int DIVSEL_BIT = 0;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_CFG    = 2'd1;
    localparam logic [1:0] REG_STATUS = 2'd2;
    localparam logic [1:0] REG_CMD    = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_FRAME,
        ST_WRAP
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_FAST = 48,
    parameter int DIV_SLOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel_slow,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CW   = $clog2(DMAX);
    localparam logic [CW-1:0] FAST_END  = CW'(DIV_FAST - 1);
    localparam logic [CW-1:0] SLOW_END  = CW'(DIV_SLOW - 1);
    localparam logic [CW-1:0] FAST_HALF = CW'(DIV_FAST / 2 - 1);
    localparam logic [CW-1:0] SLOW_HALF = CW'(DIV_SLOW / 2 - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] end_val;
    logic [CW-1:0] half_val;

    always_comb begin
        end_val  = sel_slow ? SLOW_END : FAST_END;
        half_val = sel_slow ? SLOW_HALF : FAST_HALF;
        rise_stb = run && (cnt == half_val);
        fall_stb = run && (cnt == end_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (fall_stb) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (rise_stb) mdc <= 1'b1;
        end
    end

    // R5: strobes never coincide and each finds MDC on the opposite level
    p_stb_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));
    p_rise_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !mdc);
    p_fall_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              mdio_i,
    input  logic              rise_stb,
    input  logic              fall_stb,
    output logic              run,
    output logic              idle,
    output logic              done,
    output logic              rd_op,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              oe_raw
);
    localparam int BW = $clog2(PRE_LEN);
    localparam logic [BW-1:0] LAST_BIT    = BW'(PRE_LEN - 1);
    localparam logic [BW-1:0] TA2_IDX     = BW'(CMD_W - 1 - 16);
    localparam logic [BW-1:0] CAP_IDX     = BW'(CMD_W - DATA_W);

    mdio_state_e state, nstate;
    logic [BW-1:0]    bcnt;
    logic [CMD_W-1:0] shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start) nstate = ST_PREAMBLE;
            ST_PREAMBLE: if (abort) nstate = ST_IDLE;
                         else if (fall_stb && bcnt == LAST_BIT) nstate = ST_FRAME;
            ST_FRAME:    if (abort) nstate = ST_IDLE;
                         else if (fall_stb && bcnt == LAST_BIT) nstate = ST_WRAP;
            ST_WRAP:     nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt    <= '0;
            shift   <= '0;
            rd_op   <= 1'b0;
            rd_data <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                bcnt  <= '0;
                shift <= cmd;
                rd_op <= cmd[OP_RD_BIT] & ~cmd[OP_WR_BIT];
            end
            if ((state == ST_PREAMBLE || state == ST_FRAME) && fall_stb)
                bcnt <= bcnt + 1'b1;
            if (state == ST_FRAME && fall_stb)
                shift <= {shift[CMD_W-2:0], 1'b0};
            if (state == ST_FRAME && rise_stb && bcnt >= CAP_IDX)
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        end
    end

    always_comb begin
        run    = 1'b0;
        idle   = 1'b0;
        done   = 1'b0;
        mdio_o = 1'b0;
        oe_raw = 1'b0;
        unique case (state)
            ST_IDLE:     idle = 1'b1;
            ST_PREAMBLE: begin
                run    = 1'b1;
                mdio_o = 1'b1;
                oe_raw = 1'b1;
            end
            ST_FRAME: begin
                run    = 1'b1;
                mdio_o = shift[CMD_W-1];
                oe_raw = !(rd_op && bcnt >= TA2_IDX);
            end
            ST_WRAP:     done = 1'b1;
            default:     idle = 1'b1;
        endcase
    end

    // R4: data moves only together with an MDC falling strobe
    p_mdo_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(mdio_o)) |-> $past(fall_stb));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_FAST = 48,
    parameter int DIV_SLOW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              ctrl_en;
    logic              cfg_slow;
    logic [CMD_W-1:0]  cmd_q;
    logic              start, run, idle, done, rd_op, oe_raw, mdc_raw, mdo_raw;
    logic              rise_stb, fall_stb;
    logic [DATA_W-1:0] rd_data;

    assign start = bus_wr_en && bus_addr == REG_CMD && idle && ctrl_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            cfg_slow <= 1'b0;
            cmd_q    <= '0;
        end else begin
            if (bus_wr_en && bus_addr == REG_CTRL) ctrl_en  <= bus_wdata[EN_BIT];
            if (bus_wr_en && bus_addr == REG_CFG)  cfg_slow <= bus_wdata[DIVSEL_BIT];
            if (start)
                cmd_q <= bus_wdata;
            else if (done && rd_op)
                cmd_q[DATA_W-1:0] <= rd_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL:   bus_rdata[EN_BIT]     = ctrl_en;
            REG_CFG:    bus_rdata[DIVSEL_BIT] = cfg_slow;
            REG_STATUS: bus_rdata[IDLE_BIT]   = idle;
            REG_CMD:    bus_rdata             = cmd_q;
            default:    bus_rdata             = '0;
        endcase
    end

    mdio_clkdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_slow(cfg_slow),
        .mdc(mdc_raw), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(!ctrl_en),
        .cmd(bus_wdata), .mdio_i(mdio_i), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .run(run), .idle(idle), .done(done), .rd_op(rd_op), .rd_data(rd_data),
        .mdio_o(mdo_raw), .oe_raw(oe_raw)
    );

    assign mdc     = mdc_raw & ctrl_en;
    assign mdio_oe = oe_raw & ctrl_en;
    assign mdio_o  = mdo_raw;

    // R1/R10: an idle engine keeps the bus quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));
    // R9: command word is held through a frame except the read write-back
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!idle) && !$past(done)) |-> $stable(cmd_q));
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oemask;
        int          period;
    } frame_t;

    frame_t      expq[$];
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    logic [15:0] phy_data = '0;
    int          cur_div = 48;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: collect one frame at rising MDC edges, compare against queue
    int          mon_n = 0;
    int          cyc = 0;
    int          t0 = 0;
    int          per = 0;
    logic        mdc_q = 1'b0;
    logic        mdo_q = 1'b0;
    bit          r4_bad = 0;
    logic [63:0] got_bits = '0;
    logic [63:0] got_oe = '0;

    always @(negedge clk) begin
        cyc++;
        if (mdc && mdc_q && mdio_oe && mdio_o !== mdo_q) r4_bad = 1;
        if (mdc && !mdc_q) begin
            got_bits[63-mon_n] = mdio_o;
            got_oe[63-mon_n]   = mdio_oe;
            if (mon_n == 0) t0 = cyc;
            if (mon_n == 1) per = cyc - t0;
            mon_n++;
            if (mon_n == 64) begin
                if (expq.size() == 0) begin
                    chk(0, "R3 unexpected frame", got_bits, 64'd0);
                end else begin
                    frame_t e;
                    e = expq.pop_front();
                    chk((got_bits & e.oemask) == (e.bits & e.oemask), "R3 frame bits",
                        got_bits & e.oemask, e.bits & e.oemask);
                    chk(got_oe == e.oemask, "R6/R7 output enable", got_oe, e.oemask);
                    chk(per == e.period, "R5 MDC period", 64'(per), 64'(e.period));
                    chk(!r4_bad, "R4 mdio_o stable while MDC high", 64'(r4_bad), 64'd0);
                end
                r4_bad = 0;
                mon_n = 0;
            end
        end
        // PHY model: present data after the falling edge before each rise
        if (mdc_q && !mdc) begin
            if (mon_n >= 48 && mon_n <= 63) mdio_i = phy_data[63-mon_n];
            else if (mon_n == 47)           mdio_i = 1'b0;
            else                            mdio_i = 1'b1;
        end
        mdc_q = mdc;
        mdo_q = mdio_o;
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            bus_read(2'd2, s);
            if (s[2]) break;
        end
    endtask

    // driver: push the expected frame, then issue the command
    task automatic issue(input logic [31:0] c, input logic [15:0] pd);
        frame_t e;
        logic [31:0] s;
        bit rd;
        rd = c[29] & ~c[28];
        e.bits   = {32'hFFFF_FFFF, c};
        e.oemask = rd ? ~64'h1FFFF : '1;
        e.period = cur_div;
        if (rd) e.bits[15:0] = 16'h0;
        phy_data = pd;
        expq.push_back(e);
        bus_write(2'd3, c);
        bus_read(2'd2, s);
        chk(s == 32'h0, "R8 busy after command", s, 32'h0);
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, rd, ~rd, pa, ra, 2'b10, d};
    endfunction

    initial begin
        logic [31:0] r;
        logic [31:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        bus_read(2'd2, r); chk(r == 32'h4, "R1 status after reset", r, 32'h4);
        bus_read(2'd3, r); chk(r == 32'h0, "R1 command after reset", r, 32'h0);
        chk(mdc == 0 && mdio_oe == 0, "R1 bus quiet", {mdc, mdio_oe}, 0);
        // R2 register readback
        bus_write(2'd0, 32'h10); bus_read(2'd0, r);
        chk(r == 32'h10, "R2 control readback", r, 32'h10);
        bus_write(2'd1, 32'h1); bus_read(2'd1, r);
        chk(r == 32'h1, "R2 config readback", r, 32'h1);
        bus_write(2'd1, 32'h0); cur_div = 48;
        // write frame, divider 48, with a busy write in the middle (R9)
        c = mk(0, 5'd5, 5'd3, 16'hA5C3);
        issue(c, 16'h0);
        repeat (300) @(negedge clk);
        bus_write(2'd3, mk(1, 5'd9, 5'd9, 16'h1111));
        wait_idle();
        bus_read(2'd3, r); chk(r == c, "R9 command kept", r, c);
        bus_read(2'd2, r); chk(r == 32'h4, "R8 idle after frame", r, 32'h4);
        // read frame, divider 64
        bus_write(2'd1, 32'h1); cur_div = 64;
        c = mk(1, 5'd1, 5'd2, 16'h0000);
        issue(c, 16'hBEEF);
        wait_idle();
        bus_read(2'd3, r);
        chk(r == {c[31:16], 16'hBEEF}, "R7 read data stored", r, {c[31:16], 16'hBEEF});
        // read frame, divider 48, edge data pattern
        bus_write(2'd1, 32'h0); cur_div = 48;
        c = mk(1, 5'd31, 5'd0, 16'h5555);
        issue(c, 16'h8001);
        wait_idle();
        bus_read(2'd3, r);
        chk(r == {c[31:16], 16'h8001}, "R7 read data edges", r, {c[31:16], 16'h8001});
        // write frame, divider 64, all-ones fields
        bus_write(2'd1, 32'h1); cur_div = 64;
        c = mk(0, 5'd31, 5'd31, 16'hFFFF);
        issue(c, 16'h0);
        wait_idle();
        // R10 disabled: command ignored
        bus_write(2'd0, 32'h0);
        bus_write(2'd3, mk(0, 5'd2, 5'd2, 16'h1234));
        repeat (100) @(negedge clk);
        chk(mdc == 0 && mdio_oe == 0, "R10 quiet when disabled", {mdc, mdio_oe}, 0);
        bus_read(2'd2, r); chk(r == 32'h4, "R10 idle when disabled", r, 32'h4);
        bus_read(2'd3, r); chk(r == c, "R10 command unchanged", r, c);
        // R10 abort mid-frame
        bus_write(2'd0, 32'h10);
        bus_write(2'd3, mk(0, 5'd4, 5'd4, 16'h4444));
        repeat (700) @(negedge clk);
        bus_write(2'd0, 32'h0);
        #1;
        mon_n = 0; r4_bad = 0; mdio_i = 1'b1;
        chk(mdc == 0 && mdio_oe == 0, "R10 abort quiets bus", {mdc, mdio_oe}, 0);
        bus_read(2'd2, r); chk(r == 32'h4, "R10 idle after abort", r, 32'h4);
        // clean frame after abort
        bus_write(2'd0, 32'h10); cur_div = 64;
        c = mk(0, 5'd7, 5'd16, 16'h0F0F);
        issue(c, 16'h0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R3 all frames seen", 64'(expq.size()), 64'd0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule